// File: doc/BRIEF.md
# Line-Granular Double-Buffered Burst Writer

This block takes a video stream of packed pixels (four 16-bit pixels per 64-bit beat) and stores each accepted frame in external memory through an AXI4 write channel. A line is the unit of work. Each line is cut into incrementing bursts of at most `MAX_BURST` beats, and only the last burst of a line may be shorter. The lines of a frame sit back to back from the frame's base address, so line `k` starts at base + k × line_bytes.

There are two frame buffers, A and B. One takes incoming frames while the other is held for a downstream reader. When a frame's last write response comes back, the block marks the finished buffer as ready and moves to the other one. This happens only if the reader has released the buffer it was holding. If it has not, the block writes the same buffer again and counts an overrun. A frame begins with a start-of-frame marker on its first beat. After reset, the first `WARMUP_FRAMES` frames are accepted and discarded.

Top module: `lineburst_pingpong_writer`

## Requirements
- R1: After reset, `awvalid`, `wvalid` and `frame_ready` are low, `overrun_cnt` and `err_flag` are zero, and `s_ready` is high.
- R2: The first `WARMUP_FRAMES` frames after reset are accepted and produce no AXI traffic. A frame is counted on each beat with `s_sof` high that arrives while the writer is waiting for a frame. Beats that arrive while waiting and carry no `s_sof` are also accepted and dropped.
- R3: A line of N = line_bytes/8 beats is written as a series of bursts of `MAX_BURST` beats, followed by one shorter burst of the remaining beats when N is not a multiple of `MAX_BURST`. `awlen` equals beats − 1. The line length and line count are sampled at the start of each frame.
- R4: The address of a burst is the frame base, plus line index × line_bytes, plus 8 × the beats already written in that line.
- R5: Every burst uses `awsize` = 3 (8 bytes per beat) and `awburst` = 2'b01 (incrementing). Every data beat carries `wstrb` = 8'hFF.
- R6: `wlast` is high on the final beat of every burst and on no other beat.
- R7: At most one burst is outstanding. A new `awvalid` is raised only after the write response of the previous burst has been handshaken.
- R8: The data beats of a stored frame appear on `wdata` unchanged and in arrival order. The start-of-frame beat is the first beat.
- R9: Stored frames alternate between `cfg_base_a` (buffer 0) and `cfg_base_b` (buffer 1), starting with buffer 0. One cycle after the last write response of a frame, `frame_ready` pulses for one cycle and `ready_buf` names the buffer just finished. Each `frame_ready` pulse hands that buffer to the reader. A pulse on `rd_release` returns it.
- R10: If the reader still holds its buffer when a frame completes, there is no `frame_ready` pulse. The next frame goes to the same base again, and `overrun_cnt` increases by one (saturating).
- R11: A write response other than OKAY (2'b00) sets `err_flag`. The flag stays set until reset.
- R12: Once `awvalid` is high without `awready`, it stays high with `awaddr` and `awlen` unchanged until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_a | input | ADDR_W | Base address of buffer 0 |
| cfg_base_b | input | ADDR_W | Base address of buffer 1 |
| cfg_line_bytes | input | LEN_W | Bytes per line (multiple of 8) |
| cfg_lines | input | LINES_W | Lines per frame |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_data | input | DATA_W | Packed pixel beat |
| s_sof | input | 1 | Marks the first beat of a frame |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Bytes per beat, log2 |
| awburst | output | 2 | Burst type (incrementing) |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes |
| wlast | output | 1 | Final beat of burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| rd_release | input | 1 | Reader returns its buffer |
| frame_ready | output | 1 | One-cycle pulse: a frame is complete |
| ready_buf | output | 1 | Buffer completed (0 = A, 1 = B) |
| overrun_cnt | output | OVR_W | Count of frames written with no swap |
| err_flag | output | 1 | Sticky non-OKAY response flag |

## Verification
The embedded properties assume some things about the inputs. `cfg_line_bytes` is a nonzero multiple of 8 and `cfg_lines` is nonzero whenever a stored frame starts. The memory side returns exactly one write response per burst, and only after that burst's last data beat. The stimulus sets the configuration before each frame's start marker. Its responder raises `bvalid` once per observed `wlast` handshake, and it stalls `awready` and `wready` on a fixed pattern. It uses line lengths that split into whole bursts and lengths that leave a short final burst, so the short-tail case is exercised without breaking the input rules.

// File: rtl/lbw_pkg.sv
package lbw_pkg;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_ADDR  = 2'd1,
      ST_DATA  = 2'd2,
      ST_RESP  = 2'd3
   } lbw_state_e;

   localparam logic [1:0] AXI_BURST_INCR = 2'b01;
   localparam logic [1:0] AXI_RESP_OKAY  = 2'b00;

endpackage

// File: rtl/lbw_warmup_gate.sv
module lbw_warmup_gate #(
   parameter int WARMUP_FRAMES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sof_drop,
   output logic armed
);

   generate
      if (WARMUP_FRAMES == 0) begin : g_bypass
         logic unused_gate;
         assign unused_gate = ^{clk, rst_n, sof_drop};
         assign armed = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(WARMUP_FRAMES + 1);
         logic [CW-1:0] seen_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               seen_q <= '0;
            else if (sof_drop && (seen_q != CW'(WARMUP_FRAMES)))
               seen_q <= seen_q + 1'b1;
         end

         assign armed = (seen_q == CW'(WARMUP_FRAMES));

         // R2: once armed, the gate never drops back to discarding
         assert_armed_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
            armed |=> armed)
            else $error("warm-up gate disarmed after arming");
      end
   endgenerate

endmodule

// File: rtl/lbw_burst_planner.sv
module lbw_burst_planner #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 16,
   parameter int LINES_W    = 12,
   parameter int MAX_BURST  = 256,
   parameter int BEAT_BYTES = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              frame_load,
   input  logic [ADDR_W-1:0]                 frame_base,
   input  logic [LEN_W-1:0]                  line_bytes,
   input  logic [LINES_W-1:0]                lines,
   input  logic                              burst_done,
   output logic [ADDR_W-1:0]                 cur_addr,
   output logic [$clog2(MAX_BURST+1)-1:0]    cur_beats,
   output logic                              frame_last
);

   localparam int BSHIFT = $clog2(BEAT_BYTES);
   localparam int RW     = LEN_W - BSHIFT;
   localparam int BL_W   = $clog2(MAX_BURST + 1);

   logic [ADDR_W-1:0]  addr_q;
   logic [RW-1:0]      rem_q;
   logic [RW-1:0]      line_beats_q;
   logic [LINES_W-1:0] line_q;
   logic [LINES_W-1:0] lines_q;
   logic               line_end;

   always_comb begin
      if (32'(rem_q) > MAX_BURST) begin
         cur_beats = BL_W'(MAX_BURST);
         line_end  = 1'b0;
      end else begin
         cur_beats = BL_W'(rem_q);
         line_end  = 1'b1;
      end
   end

   assign cur_addr   = addr_q;
   assign frame_last = line_end && (line_q == lines_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q       <= '0;
         rem_q        <= '0;
         line_beats_q <= '0;
         line_q       <= '0;
         lines_q      <= '0;
      end else if (frame_load) begin
         addr_q       <= frame_base;
         rem_q        <= line_bytes[LEN_W-1:BSHIFT];
         line_beats_q <= line_bytes[LEN_W-1:BSHIFT];
         line_q       <= '0;
         lines_q      <= lines;
      end else if (burst_done) begin
         addr_q <= addr_q + (ADDR_W'(cur_beats) << BSHIFT);
         if (line_end) begin
            rem_q  <= line_beats_q;
            line_q <= line_q + 1'b1;
         end else begin
            rem_q  <= rem_q - RW'(cur_beats);
         end
      end
   end

   // R3: a stored frame needs at least one beat per line and one line
   assert_line_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_load |-> (line_bytes[LEN_W-1:BSHIFT] != '0) && (lines != '0))
      else $error("frame started with empty geometry");

   // R3: every completed burst carried between one and MAX_BURST beats
   assert_burst_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |-> (cur_beats != '0))
      else $error("zero-length burst completed");

endmodule

// File: rtl/lbw_pingpong_ctrl.sv
module lbw_pingpong_ctrl #(
   parameter int OVR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_complete,
   input  logic             rd_release,
   output logic             wr_buf,
   output logic             frame_ready,
   output logic             ready_buf,
   output logic [OVR_W-1:0] overrun_cnt
);

   logic held_q;
   logic swap_ok;

   assign swap_ok = frame_complete && (!held_q || rd_release);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q      <= 1'b0;
         wr_buf      <= 1'b0;
         frame_ready <= 1'b0;
         ready_buf   <= 1'b0;
         overrun_cnt <= '0;
      end else begin
         frame_ready <= swap_ok;
         if (swap_ok) begin
            held_q    <= 1'b1;
            ready_buf <= wr_buf;
            wr_buf    <= ~wr_buf;
         end else if (rd_release) begin
            held_q <= 1'b0;
         end
         if (frame_complete && !swap_ok && (overrun_cnt != '1))
            overrun_cnt <= overrun_cnt + 1'b1;
      end
   end

   // R9: a ready pulse always coincides with the writer having moved buffers
   assert_swap_on_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_ready |-> (wr_buf != $past(wr_buf)) && (ready_buf == $past(wr_buf)))
      else $error("ready pulse without buffer swap");

   // R10: the overrun count only ever steps up by one
   assert_overrun_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_cnt != $past(overrun_cnt)) |-> (overrun_cnt == OVR_W'($past(overrun_cnt) + 1'b1)))
      else $error("overrun count moved by other than +1");

endmodule

// File: rtl/lineburst_pingpong_writer.sv
module lineburst_pingpong_writer
   import lbw_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 64,
   parameter int PIX_W         = 16,
   parameter int LEN_W         = 16,
   parameter int LINES_W       = 12,
   parameter int MAX_BURST     = 256,
   parameter int WARMUP_FRAMES = 8,
   parameter int OVR_W         = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cfg_base_a,
   input  logic [ADDR_W-1:0]    cfg_base_b,
   input  logic [LEN_W-1:0]     cfg_line_bytes,
   input  logic [LINES_W-1:0]   cfg_lines,
   input  logic                 s_valid,
   output logic                 s_ready,
   input  logic [DATA_W-1:0]    s_data,
   input  logic                 s_sof,
   output logic                 awvalid,
   input  logic                 awready,
   output logic [ADDR_W-1:0]    awaddr,
   output logic [7:0]           awlen,
   output logic [2:0]           awsize,
   output logic [1:0]           awburst,
   output logic                 wvalid,
   input  logic                 wready,
   output logic [DATA_W-1:0]    wdata,
   output logic [DATA_W/8-1:0]  wstrb,
   output logic                 wlast,
   input  logic                 bvalid,
   output logic                 bready,
   input  logic [1:0]           bresp,
   input  logic                 rd_release,
   output logic                 frame_ready,
   output logic                 ready_buf,
   output logic [OVR_W-1:0]     overrun_cnt,
   output logic                 err_flag
);

   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int BSHIFT     = $clog2(BEAT_BYTES);
   localparam int BL_W       = $clog2(MAX_BURST + 1);

   generate
      if ((MAX_BURST < 1) || (MAX_BURST > 256)) begin : g_bad_burst
         $error("MAX_BURST must lie in 1..256");
      end
      if ((DATA_W % PIX_W) != 0) begin : g_bad_pack
         $error("DATA_W must hold a whole number of pixels");
      end
      if ((BEAT_BYTES < 1) || ((1 << BSHIFT) != BEAT_BYTES) || (BSHIFT > 7)) begin : g_bad_beat
         $error("DATA_W must be a power-of-two byte count up to 128 bytes");
      end
      if (LEN_W <= BSHIFT) begin : g_bad_len
         $error("LEN_W too narrow for one beat");
      end
   endgenerate

   lbw_state_e          state_q;
   logic                armed;
   logic                sof_drop;
   logic                frame_load;
   logic                aw_fire;
   logic                w_fire;
   logic                b_fire;
   logic                frame_complete;
   logic                wr_buf;
   logic [ADDR_W-1:0]   cur_addr;
   logic [BL_W-1:0]     cur_beats;
   logic                frame_last;
   logic [BL_W-1:0]     wcnt_q;

   // ---------------- handshakes and stream steering ----------------
   assign sof_drop   = (state_q == ST_WAIT) && s_valid && s_sof && !armed;
   assign frame_load = (state_q == ST_WAIT) && s_valid && s_sof && armed;
   assign aw_fire    = awvalid && awready;
   assign w_fire     = wvalid && wready;
   assign b_fire     = bvalid && bready;
   assign frame_complete = b_fire && frame_last;

   always_comb begin
      unique case (state_q)
         ST_WAIT: s_ready = !(s_sof && armed);
         ST_DATA: s_ready = wready;
         default: s_ready = 1'b0;
      endcase
   end

   assign awvalid = (state_q == ST_ADDR);
   assign awaddr  = cur_addr;
   assign awlen   = 8'(cur_beats - BL_W'(1));
   assign awsize  = 3'(BSHIFT);
   assign awburst = AXI_BURST_INCR;
   assign wvalid  = (state_q == ST_DATA) && s_valid;
   assign wdata   = s_data;
   assign wstrb   = '1;
   assign wlast   = (wcnt_q == BL_W'(1));
   assign bready  = (state_q == ST_RESP);

   // ---------------- sequencing ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_WAIT;
         wcnt_q   <= '0;
         err_flag <= 1'b0;
      end else begin
         unique case (state_q)
            ST_WAIT: if (frame_load) state_q <= ST_ADDR;
            ST_ADDR: if (aw_fire) begin
               state_q <= ST_DATA;
               wcnt_q  <= cur_beats;
            end
            ST_DATA: if (w_fire) begin
               wcnt_q <= wcnt_q - 1'b1;
               if (wlast) state_q <= ST_RESP;
            end
            ST_RESP: if (b_fire) begin
               state_q <= frame_last ? ST_WAIT : ST_ADDR;
            end
            default: state_q <= ST_WAIT;
         endcase
         if (b_fire && (bresp != AXI_RESP_OKAY))
            err_flag <= 1'b1;
      end
   end

   // ---------------- sub-blocks ----------------
   lbw_warmup_gate #(
      .WARMUP_FRAMES (WARMUP_FRAMES)
   ) u_warmup (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof_drop (sof_drop),
      .armed    (armed)
   );

   lbw_burst_planner #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .LINES_W    (LINES_W),
      .MAX_BURST  (MAX_BURST),
      .BEAT_BYTES (BEAT_BYTES)
   ) u_planner (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_load (frame_load),
      .frame_base (wr_buf ? cfg_base_b : cfg_base_a),
      .line_bytes (cfg_line_bytes),
      .lines      (cfg_lines),
      .burst_done (b_fire),
      .cur_addr   (cur_addr),
      .cur_beats  (cur_beats),
      .frame_last (frame_last)
   );

   lbw_pingpong_ctrl #(
      .OVR_W (OVR_W)
   ) u_pingpong (
      .clk            (clk),
      .rst_n          (rst_n),
      .frame_complete (frame_complete),
      .rd_release     (rd_release),
      .wr_buf         (wr_buf),
      .frame_ready    (frame_ready),
      .ready_buf      (ready_buf),
      .overrun_cnt    (overrun_cnt)
   );

   // ---------------- protocol checks ----------------
   logic            outst_q;
   logic [BL_W-1:0] wbeat_q;
   logic [7:0]      len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst_q <= 1'b0;
         wbeat_q <= '0;
         len_q   <= '0;
      end else begin
         if (aw_fire) begin
            outst_q <= 1'b1;
            len_q   <= awlen;
            wbeat_q <= '0;
         end else if (w_fire) begin
            wbeat_q <= wbeat_q + 1'b1;
         end
         if (b_fire) outst_q <= 1'b0;
      end
   end

   assert_aw_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && !awready) |=> awvalid && $stable(awaddr) && $stable(awlen))
      else $error("address request withdrawn or changed");

   assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
      awvalid |-> !outst_q)
      else $error("new burst issued before response");

   assert_wlast_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      w_fire |-> (wlast == (8'(wbeat_q) == len_q)))
      else $error("last-beat flag misplaced");

   assert_warmup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !awvalid && !wvalid)
      else $error("traffic during warm-up");

   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag)
      else $error("error flag cleared");

endmodule

// File: tb/lineburst_pingpong_writer_bench.sv
module lineburst_pingpong_writer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int MAXB       = 4;
   localparam int WARM       = 2;
   localparam logic [31:0] BASE_A = 32'h0000_1000;
   localparam logic [31:0] BASE_B = 32'h0000_8000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_base_a = BASE_A;
   logic [31:0] cfg_base_b = BASE_B;
   logic [15:0] cfg_line_bytes = 16'd80;
   logic [11:0] cfg_lines = 12'd2;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [63:0] s_data = '0;
   logic        s_sof = 1'b0;
   logic        awvalid;
   logic        awready = 1'b1;
   logic [31:0] awaddr;
   logic [7:0]  awlen;
   logic [2:0]  awsize;
   logic [1:0]  awburst;
   logic        wvalid;
   logic        wready = 1'b1;
   logic [63:0] wdata;
   logic [7:0]  wstrb;
   logic        wlast;
   logic        bvalid = 1'b0;
   logic        bready;
   logic [1:0]  bresp = 2'b00;
   logic        rd_release = 1'b0;
   logic        frame_ready;
   logic        ready_buf;
   logic [7:0]  overrun_cnt;
   logic        err_flag;

   always #(CLK_PERIOD/2) clk = ~clk;

   lineburst_pingpong_writer #(
      .MAX_BURST     (MAXB),
      .WARMUP_FRAMES (WARM)
   ) u_lineburst_pingpong_writer (
      .clk(clk), .rst_n(rst_n),
      .cfg_base_a(cfg_base_a), .cfg_base_b(cfg_base_b),
      .cfg_line_bytes(cfg_line_bytes), .cfg_lines(cfg_lines),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof),
      .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
      .awsize(awsize), .awburst(awburst),
      .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
      .bvalid(bvalid), .bready(bready), .bresp(bresp),
      .rd_release(rd_release), .frame_ready(frame_ready), .ready_buf(ready_buf),
      .overrun_cnt(overrun_cnt), .err_flag(err_flag)
   );

   typedef struct { logic [31:0] addr; logic [7:0] len; } aw_item_t;
   typedef struct { logic [63:0] data; logic last; } w_item_t;

   aw_item_t exp_aw[$];
   w_item_t  exp_w[$];
   logic     exp_rdy[$];

   int  n_cmp = 0;
   int  n_bad = 0;
   int  aw_seen = 0;
   int  cyc = 0;
   int  b_index = 0;
   int  err_at = -1;
   bit  aw_stall = 0;
   bit  w_stall = 0;
   bit  out_flag = 0;
   bit  wlast_pend = 0;
   bit  b_fire_pend = 0;
   bit  aw_wait = 0;
   logic [31:0] aw_wait_addr;
   logic [7:0]  aw_wait_len;
   bit  done = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- memory-side responder ----------------
   always @(posedge clk) begin
      #1;
      cyc++;
      awready = aw_stall ? ((cyc % 3) == 2) : 1'b1;
      wready  = w_stall  ? ((cyc % 2) == 0) : 1'b1;
      if (b_fire_pend) begin
         bvalid = 1'b0;
         b_fire_pend = 0;
      end
      if (wlast_pend) begin
         bvalid = 1'b1;
         bresp  = (b_index == err_at) ? 2'b10 : 2'b00;
         b_index++;
         wlast_pend = 0;
      end
   end

   // ---------------- monitor / scoreboard ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         if (aw_wait) begin
            // R12: a stalled request stays put
            chk("R12 aw held", {31'd0, awvalid, awaddr}, {31'd0, 1'b1, aw_wait_addr});
            chk("R12 len held", {56'd0, awlen}, {56'd0, aw_wait_len});
         end
         aw_wait = awvalid && !awready;
         aw_wait_addr = awaddr;
         aw_wait_len  = awlen;

         if (awvalid && awready) begin
            aw_seen++;
            chk("R7 no outstanding burst", {63'd0, out_flag}, 64'd0);
            out_flag = 1;
            if (exp_aw.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R2/R3 unexpected burst actual=%h expected=none", awaddr);
            end else begin
               aw_item_t e;
               e = exp_aw.pop_front();
               chk("R4 burst address", {32'd0, awaddr}, {32'd0, e.addr});
               chk("R3 burst length", {56'd0, awlen}, {56'd0, e.len});
            end
            chk("R5 awsize", {61'd0, awsize}, 64'd3);
            chk("R5 awburst", {62'd0, awburst}, 64'd1);
         end

         if (wvalid && wready) begin
            if (exp_w.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R2/R8 unexpected beat actual=%h expected=none", wdata);
            end else begin
               w_item_t e;
               e = exp_w.pop_front();
               chk("R8 write data", wdata, e.data);
               chk("R6 wlast", {63'd0, wlast}, {63'd0, e.last});
            end
            chk("R5 wstrb", {56'd0, wstrb}, 64'hFF);
            if (wlast) wlast_pend = 1;
         end

         if (bvalid && bready) begin
            out_flag = 0;
            b_fire_pend = 1;
         end

         if (frame_ready) begin
            if (exp_rdy.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R9/R10 unexpected ready actual=%0d expected=none", ready_buf);
            end else begin
               logic eb;
               eb = exp_rdy.pop_front();
               chk("R9 ready buffer", {63'd0, ready_buf}, {63'd0, eb});
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic send_beat(input logic [63:0] d, input logic sof);
      s_valid = 1'b1;
      s_data  = d;
      s_sof   = sof;
      forever begin
         @(negedge clk);
         if (s_ready) break;
      end
      @(posedge clk); #1;
      s_valid = 1'b0;
      s_sof   = 1'b0;
   endtask

   task automatic send_frame(input int fid, input int nlines, input int lbytes,
                             input bit store, input logic [31:0] base);
      int beats;
      beats = lbytes / 8;
      cfg_line_bytes = 16'(lbytes);
      cfg_lines = 12'(nlines);
      if (store) begin
         logic [31:0] a;
         a = base;
         for (int l = 0; l < nlines; l++) begin
            int rem;
            int bi;
            rem = beats;
            bi = 0;
            while (rem > 0) begin
               int nb;
               aw_item_t ai;
               nb = (rem > MAXB) ? MAXB : rem;
               ai.addr = a;
               ai.len = 8'(nb - 1);
               exp_aw.push_back(ai);
               for (int k = 0; k < nb; k++) begin
                  w_item_t wi;
                  wi.data = {16'(16'hF000 + fid), 16'(l), 16'(bi), 16'hA5A5};
                  wi.last = (k == nb - 1);
                  exp_w.push_back(wi);
                  bi++;
               end
               a = a + 32'(nb * 8);
               rem = rem - nb;
            end
         end
      end
      for (int l = 0; l < nlines; l++)
         for (int b = 0; b < beats; b++)
            send_beat({16'(16'hF000 + fid), 16'(l), 16'(b), 16'hA5A5}, (l == 0) && (b == 0));
   endtask

   task automatic wait_drain();
      while (exp_aw.size() != 0 || exp_w.size() != 0 || out_flag || bvalid)
         @(posedge clk);
      repeat (4) @(posedge clk);
      #1;
   endtask

   task automatic release_pulse();
      rd_release = 1'b1;
      @(posedge clk); #1;
      rd_release = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 awvalid", {63'd0, awvalid}, 64'd0);
      chk("R1 wvalid", {63'd0, wvalid}, 64'd0);
      chk("R1 frame_ready", {63'd0, frame_ready}, 64'd0);
      chk("R1 overrun", {56'd0, overrun_cnt}, 64'd0);
      chk("R1 err", {63'd0, err_flag}, 64'd0);
      chk("R1 s_ready", {63'd0, s_ready}, 64'd1);
      @(posedge clk); #1;

      // R2: stray beats and warm-up frames are dropped
      send_beat(64'hDEAD_0000_0000_0001, 1'b0);
      send_beat(64'hDEAD_0000_0000_0002, 1'b0);
      send_frame(1, 2, 80, 0, BASE_A);
      send_frame(2, 1, 32, 0, BASE_A);
      repeat (6) @(posedge clk); #1;
      chk("R2 no bursts during warm-up", 64'(aw_seen), 64'd0);

      // R3/R4/R9: frame into A, 10-beat lines -> 4,4,2
      exp_rdy.push_back(1'b0);
      send_frame(3, 2, 80, 1, BASE_A);
      wait_drain();
      chk("R9 first frame signalled", 64'(exp_rdy.size()), 64'd0);
      chk("R3 burst count frame 3", 64'(aw_seen), 64'd6);

      // R12/R3: stalled handshakes, 8-beat lines -> whole bursts, into B
      release_pulse();
      aw_stall = 1; w_stall = 1;
      exp_rdy.push_back(1'b1);
      send_frame(4, 3, 64, 1, BASE_B);
      wait_drain();
      aw_stall = 0; w_stall = 0;
      chk("R9 second frame signalled", 64'(exp_rdy.size()), 64'd0);

      // R10: reader still holds B, frame rewrites A with no ready pulse
      send_beat(64'hBEEF_0000_0000_0003, 1'b0);
      send_frame(5, 1, 24, 1, BASE_A);
      wait_drain();
      chk("R10 overrun count", {56'd0, overrun_cnt}, 64'd1);
      chk("R11 err still clear", {63'd0, err_flag}, 64'd0);

      // R11/R10: after release, same buffer A again; inject an error response
      release_pulse();
      err_at = b_index + 1;
      exp_rdy.push_back(1'b0);
      send_frame(6, 2, 40, 1, BASE_A);
      wait_drain();
      chk("R11 err set", {63'd0, err_flag}, 64'd1);
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R11 err sticky", {63'd0, err_flag}, 64'd1);
      chk("R10 overrun unchanged", {56'd0, overrun_cnt}, 64'd1);
      chk("R9 all ready pulses seen", 64'(exp_rdy.size()), 64'd0);
      chk("R8 all beats seen", 64'(exp_w.size()), 64'd0);
      done = 1;
      finish_run();
   end

endmodule